// File: doc/BRIEF.md
# Jump Target Cache

This block sits beside the decode stage of a four-stage in-order pipeline (fetch, decode, execute, write-back) and removes the fetch bubble from jumps that repeat, as in a tight loop. Every cycle the decoder presents a jump descriptor: a valid flag, a flag saying whether the jump belongs to the cacheable class, whether its condition is taken, the address of the jump instruction and the address of its target. A taken jump normally costs one extra cycle. The block signals that cycle with a bubble request while the target is fetched.

When a taken cacheable jump misses, the block remembers the jump address and its target address. It then watches the fetch-return port. When the word fetched from that target address comes back, the block stores it as the single cache entry, tagged with the full jump address. The next taken occurrence of the same jump hits. The stored target word is then handed straight to decode, the hit flag is raised, and no bubble is requested. Any instruction that can change the code segment, and any serviced standard interrupt, drops the entry and any fill still waiting.

Top module: `jtc_top`

## Requirements
- R1: After reset the entry is empty: with a taken cacheable jump presented, `hit_o` is 0. With no jump presented, `hit_o`, `bubble_o` and `inj_word_o` are all 0.
- R2: A descriptor with `dec_valid_i`=0 or `dec_taken_i`=0 gives `hit_o`=0 and `bubble_o`=0 in that cycle, and leaves the entry unchanged.
- R3: A taken jump that does not hit raises `bubble_o` in the same cycle, and `hit_o` stays 0.
- R4: After a taken cacheable miss, the first later `fr_valid_i` whose `fr_addr_i` equals the recorded target address stores `fr_word_i`. From the next cycle on, a taken cacheable descriptor with the same jump address gives `hit_o`=1, `bubble_o`=0 and `inj_word_o` equal to the stored word, in the same cycle.
- R5: A fetch return whose address differs from the recorded target, or that arrives with no fill pending, changes nothing.
- R6: A hit needs all address bits to match. A taken cacheable jump at another address misses, clears the entry and re-arms the fill for itself.
- R7: A taken jump with `dec_cacheable_i`=0 never hits, requests a bubble, and neither fills nor clears the entry.
- R8: `inval_seg_i` high in a cycle clears the entry and any pending fill from the next cycle on.
- R9: `inval_irq_i` high in a cycle clears the entry and any pending fill from the next cycle on.
- R10: An invalidate in the same cycle as a matching fetch return wins: nothing is stored.
- R11: `inj_word_o` is 0 in every cycle without a hit.
- R12: A new taken cacheable miss in the same cycle as a matching fetch return for the older miss wins: the older word is not stored, and the newer jump waits for its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | Decode holds a jump descriptor |
| dec_cacheable_i | input | 1 | Jump belongs to the cacheable class |
| dec_taken_i | input | 1 | Jump condition met |
| dec_addr_i | input | ADDR_W | Address of the jump instruction |
| dec_target_i | input | ADDR_W | Address of the jump target |
| fr_valid_i | input | 1 | Fetch return carries a word |
| fr_addr_i | input | ADDR_W | Address of the returned word |
| fr_word_i | input | WORD_W | Returned instruction word |
| inval_seg_i | input | 1 | A code-segment-changing instruction executes |
| inval_irq_i | input | 1 | A standard interrupt is serviced |
| hit_o | output | 1 | Cached target is injected this cycle |
| inj_word_o | output | WORD_W | Injected target word, 0 without a hit |
| bubble_o | output | 1 | Request a bubble into decode |

## Verification
The bench builds the block with ADDR_W=8 and WORD_W=16. The narrow address lets it place two jumps that differ only in the top bit or only in the bottom bit. This exercises the full-tag compare at both ends of the address. The narrow word keeps distinct target words easy to tell apart in the comparison. With these values, sequences of a handful of cycles reach the same-cycle collisions of invalidate, fill and re-arm.

// File: rtl/jtc_pkg.sv
package jtc_pkg;
  // Cause of an update to the cache entry, in priority order (kill first)
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_KILL = 2'd1,
    UPD_DROP = 2'd2,
    UPD_FILL = 2'd3
  } upd_e;
endpackage

// File: rtl/jtc_match.sv
module jtc_match #(
  parameter int ADDR_W = 24
) (
  input  logic              ent_valid_i,
  input  logic [ADDR_W-1:0] ent_tag_i,
  input  logic              dec_valid_i,
  input  logic              dec_cacheable_i,
  input  logic              dec_taken_i,
  input  logic [ADDR_W-1:0] dec_addr_i,
  output logic              hit_o,
  output logic              miss_c_o,
  output logic              bubble_o
);
  logic taken;
  logic tag_eq;

  always_comb begin
    taken    = dec_valid_i && dec_taken_i;
    tag_eq   = (ent_tag_i == dec_addr_i);
    hit_o    = taken && dec_cacheable_i && ent_valid_i && tag_eq;
    miss_c_o = taken && dec_cacheable_i && !hit_o;
    bubble_o = taken && !hit_o;
  end
endmodule

// File: rtl/jtc_fill_ctl.sv
module jtc_fill_ctl #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill_i,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] arm_tag_i,
  input  logic [ADDR_W-1:0] arm_tgt_i,
  input  logic              fr_valid_i,
  input  logic [ADDR_W-1:0] fr_addr_i,
  output logic              fill_o,
  output logic [ADDR_W-1:0] fill_tag_o
);
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] ptag_q, ptag_d;
  logic [ADDR_W-1:0] ptgt_q, ptgt_d;
  logic              addr_en;

  always_comb begin
    fill_o     = pend_q && fr_valid_i && (fr_addr_i == ptgt_q) && !kill_i && !arm_i;
    fill_tag_o = ptag_q;
    pend_d     = pend_q;
    addr_en    = 1'b0;
    ptag_d     = arm_tag_i;
    ptgt_d     = arm_tgt_i;
    if (kill_i) begin
      pend_d = 1'b0;
    end else if (arm_i) begin
      pend_d  = 1'b1;
      addr_en = 1'b1;
    end else if (fill_o) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) begin
      ptag_q <= ptag_d;
      ptgt_q <= ptgt_d;
    end
  end
endmodule

// File: rtl/jtc_store.sv
module jtc_store
  import jtc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill_i,
  input  logic              drop_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_tag_i,
  input  logic [WORD_W-1:0] fill_word_i,
  output logic              ent_valid_o,
  output logic [ADDR_W-1:0] ent_tag_o,
  output logic [WORD_W-1:0] ent_word_o
);
  upd_e              cause;
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] tag_q;
  logic [WORD_W-1:0] word_q;
  logic              data_en;

  always_comb begin
    if (kill_i)      cause = UPD_KILL;
    else if (drop_i) cause = UPD_DROP;
    else if (fill_i) cause = UPD_FILL;
    else             cause = UPD_NONE;
    valid_d = valid_q;
    data_en = 1'b0;
    case (cause)
      UPD_KILL, UPD_DROP: valid_d = 1'b0;
      UPD_FILL: begin
        valid_d = 1'b1;
        data_en = 1'b1;
      end
      default: valid_d = valid_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      tag_q  <= fill_tag_i;
      word_q <= fill_word_i;
    end
  end

  assign ent_valid_o = valid_q;
  assign ent_tag_o   = tag_q;
  assign ent_word_o  = word_q;
endmodule

// File: rtl/jtc_top.sv
module jtc_top #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid_i,
  input  logic              dec_cacheable_i,
  input  logic              dec_taken_i,
  input  logic [ADDR_W-1:0] dec_addr_i,
  input  logic [ADDR_W-1:0] dec_target_i,
  input  logic              fr_valid_i,
  input  logic [ADDR_W-1:0] fr_addr_i,
  input  logic [WORD_W-1:0] fr_word_i,
  input  logic              inval_seg_i,
  input  logic              inval_irq_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] inj_word_o,
  output logic              bubble_o
);
  logic              kill;
  logic              miss_c;
  logic              fill;
  logic [ADDR_W-1:0] fill_tag;
  logic              ent_valid;
  logic [ADDR_W-1:0] ent_tag;
  logic [WORD_W-1:0] ent_word;

  assign kill = inval_seg_i || inval_irq_i;

  jtc_match #(.ADDR_W(ADDR_W)) u_match (
    .ent_valid_i     (ent_valid),
    .ent_tag_i       (ent_tag),
    .dec_valid_i     (dec_valid_i),
    .dec_cacheable_i (dec_cacheable_i),
    .dec_taken_i     (dec_taken_i),
    .dec_addr_i      (dec_addr_i),
    .hit_o           (hit_o),
    .miss_c_o        (miss_c),
    .bubble_o        (bubble_o)
  );

  jtc_fill_ctl #(.ADDR_W(ADDR_W)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill_i     (kill),
    .arm_i      (miss_c),
    .arm_tag_i  (dec_addr_i),
    .arm_tgt_i  (dec_target_i),
    .fr_valid_i (fr_valid_i),
    .fr_addr_i  (fr_addr_i),
    .fill_o     (fill),
    .fill_tag_o (fill_tag)
  );

  jtc_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .kill_i      (kill),
    .drop_i      (miss_c),
    .fill_i      (fill),
    .fill_tag_i  (fill_tag),
    .fill_word_i (fr_word_i),
    .ent_valid_o (ent_valid),
    .ent_tag_o   (ent_tag),
    .ent_word_o  (ent_word)
  );

  assign inj_word_o = hit_o ? ent_word : '0;
endmodule

// File: rtl/jtc_chk.sv
module jtc_chk #(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_valid_i,
  input logic              dec_cacheable_i,
  input logic              dec_taken_i,
  input logic [ADDR_W-1:0] dec_addr_i,
  input logic              fr_valid_i,
  input logic              inval_seg_i,
  input logic              inval_irq_i,
  input logic              hit_o,
  input logic [WORD_W-1:0] inj_word_o,
  input logic              bubble_o
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid_i && dec_taken_i) |-> (!hit_o && !bubble_o));

  a_r3_hit_or_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && bubble_o));

  a_r4_word_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && $past(hit_o) && !$past(fr_valid_i) && dec_addr_i == $past(dec_addr_i))
      |-> inj_word_o == $past(inj_word_o));

  a_r7_uncached_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_cacheable_i |-> !hit_o);

  a_r8_seg_flush: assert property (@(posedge clk) disable iff (!rst_n)
    inval_seg_i |=> !hit_o);

  a_r9_irq_flush: assert property (@(posedge clk) disable iff (!rst_n)
    inval_irq_i |=> !hit_o);

  a_r11_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> inj_word_o == '0);
endmodule

bind jtc_top jtc_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .dec_valid_i     (dec_valid_i),
  .dec_cacheable_i (dec_cacheable_i),
  .dec_taken_i     (dec_taken_i),
  .dec_addr_i      (dec_addr_i),
  .fr_valid_i      (fr_valid_i),
  .inval_seg_i     (inval_seg_i),
  .inval_irq_i     (inval_irq_i),
  .hit_o           (hit_o),
  .inj_word_o      (inj_word_o),
  .bubble_o        (bubble_o)
);

// File: tb/jtc_top_tb_top.sv
`timescale 1ns/1ps
module jtc_top_tb_top;
  localparam int AW = 8;
  localparam int WW = 16;

  logic          clk;
  logic          rst_n;
  logic          dv, dc, dt;
  logic [AW-1:0] da, dtg;
  logic          frv;
  logic [AW-1:0] fra;
  logic [WW-1:0] frw;
  logic          iseg, iirq;
  logic          hit;
  logic [WW-1:0] iw;
  logic          bub;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit          m_valid;
  bit [AW-1:0] m_tag;
  bit [WW-1:0] m_word;
  bit          p_valid;
  bit [AW-1:0] p_tag;
  bit [AW-1:0] p_tgt;

  jtc_top #(.ADDR_W(AW), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_valid_i(dv), .dec_cacheable_i(dc), .dec_taken_i(dt),
    .dec_addr_i(da), .dec_target_i(dtg),
    .fr_valid_i(frv), .fr_addr_i(fra), .fr_word_i(frw),
    .inval_seg_i(iseg), .inval_irq_i(iirq),
    .hit_o(hit), .inj_word_o(iw), .bubble_o(bub)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input bit v, input bit c, input bit t,
                      input bit [AW-1:0] a, input bit [AW-1:0] tg,
                      input bit fv, input bit [AW-1:0] fa, input bit [WW-1:0] fw,
                      input bit ks, input bit ki, input string req);
    bit          e_hit, e_bub, fire, kill, arm;
    bit [WW-1:0] e_w;
    dv = v; dc = c; dt = t; da = a; dtg = tg;
    frv = fv; fra = fa; frw = fw; iseg = ks; iirq = ki;
    #1;
    e_hit = v && t && c && m_valid && (m_tag == a);
    e_bub = v && t && !e_hit;
    e_w   = e_hit ? m_word : '0;
    checks++;
    if (hit !== e_hit || bub !== e_bub || iw !== e_w) begin
      fails++;
      $display("FAIL %s: hit/bubble/word actual %0b/%0b/%h expected %0b/%0b/%h",
               req, hit, bub, iw, e_hit, e_bub, e_w);
    end
    kill = ks || ki;
    arm  = v && t && c && !e_hit;
    fire = p_valid && fv && (fa == p_tgt) && !kill && !arm;
    @(posedge clk);
    if (kill) begin
      m_valid = 0; p_valid = 0;
    end else if (arm) begin
      m_valid = 0; p_valid = 1; p_tag = a; p_tgt = tg;
    end else if (fire) begin
      m_valid = 1; m_tag = p_tag; m_word = fw; p_valid = 0;
    end
    @(negedge clk);
  endtask

  task automatic jmp(input bit c, input bit [AW-1:0] a, input bit [AW-1:0] tg, input string req);
    step(1, c, 1, a, tg, 0, 0, 0, 0, 0, req);
  endtask

  task automatic ret(input bit [AW-1:0] fa, input bit [WW-1:0] fw, input string req);
    step(0, 0, 0, 0, 0, 1, fa, fw, 0, 0, req);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_valid = 0; p_valid = 0; m_tag = 0; m_word = 0; p_tag = 0; p_tgt = 0;
    rst_n = 0;
    dv = 0; dc = 0; dt = 0; da = 0; dtg = 0; frv = 0; fra = 0; frw = 0; iseg = 0; iirq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, quiet and then a taken cacheable jump misses
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    jmp(1, 8'h10, 8'h40, "R1");
    // R2: not-taken and invalid descriptors
    step(1, 1, 0, 8'h10, 8'h40, 0, 0, 0, 0, 0, "R2");
    step(0, 1, 1, 8'h10, 8'h40, 0, 0, 0, 0, 0, "R2");
    // R5: wrong fetch address ignored, then R4 fill and hit
    ret(8'h41, 16'hDEAD, "R5");
    jmp(1, 8'h10, 8'h40, "R5");
    ret(8'h40, 16'hA5A5, "R4");
    jmp(1, 8'h10, 8'h40, "R4");
    jmp(1, 8'h10, 8'h40, "R4");
    step(1, 1, 0, 8'h10, 8'h40, 0, 0, 0, 0, 0, "R2");
    jmp(1, 8'h10, 8'h40, "R2");
    // R7: uncached taken jump at the same address
    jmp(0, 8'h10, 8'h40, "R7");
    jmp(1, 8'h10, 8'h40, "R7");
    // R5: spurious return with nothing pending
    ret(8'h40, 16'h9999, "R5");
    jmp(1, 8'h10, 8'h40, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    // R6: neighbour addresses in bottom and top bit
    jmp(1, 8'h11, 8'h50, "R6");
    jmp(1, 8'h10, 8'h40, "R6");
    ret(8'h40, 16'h1234, "R6");
    jmp(1, 8'h90, 8'h60, "R6");
    ret(8'h60, 16'h7777, "R6");
    jmp(1, 8'h90, 8'h60, "R6");
    jmp(1, 8'h10, 8'h40, "R6");
    ret(8'h40, 16'h4321, "R6");
    jmp(1, 8'h10, 8'h40, "R6");
    // R8: segment change flushes
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    jmp(1, 8'h10, 8'h40, "R8");
    // R9: interrupt cancels pending fill
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    ret(8'h40, 16'h5555, "R9");
    jmp(1, 8'h10, 8'h40, "R9");
    // R10: invalidate beats same-cycle fill
    step(0, 0, 0, 0, 0, 1, 8'h40, 16'h6666, 1, 0, "R10");
    jmp(1, 8'h10, 8'h40, "R10");
    step(0, 0, 0, 0, 0, 1, 8'h40, 16'h6767, 0, 1, "R10");
    jmp(1, 8'h10, 8'h40, "R10");
    // R12: new miss beats same-cycle fill of older miss
    step(1, 1, 1, 8'h22, 8'h70, 1, 8'h40, 16'h8888, 0, 0, "R12");
    jmp(1, 8'h10, 8'h40, "R12");
    jmp(1, 8'h22, 8'h70, "R12");
    ret(8'h70, 16'hBEEF, "R12");
    jmp(1, 8'h22, 8'h70, "R12");
    // R3: uncached taken jump elsewhere does not disturb entry
    jmp(0, 8'h33, 8'h80, "R3");
    ret(8'h80, 16'h0F0F, "R3");
    jmp(1, 8'h22, 8'h70, "R3");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule